// File: doc/BRIEF.md
# Power-Good Sequencing Monitor

This block decides when a regulated supply rail may be reported as good. Two comparator flags come in from analog circuitry outside the block. One says the rail is above the upper (assert) threshold, set at 90 percent of nominal. The other says the rail is below the lower (release) threshold, set at 80 percent of nominal. The 10 percent gap between them gives the indication hysteresis. A soft-start-complete status, a latched-fault status and a single-cycle time-base tick also come in. All delays are counted in ticks of that time base.

Once the rail crosses the upper threshold, a long qualification delay starts. It is a few milliseconds in a real system (typically 3 ms, kept within 1 to 10 ms). The indication goes good only when that delay runs out and the rail has not dropped below the lower threshold in the meantime. Once good, the indication stays good until the rail has been continuously below the lower threshold for a short release delay of about 15 microseconds. A dip that recovers before the release delay ends is ignored. The pin is open-drain, so the block only drives a pull-low enable. The external pull-up supplies the high, good level.

Top module: `pgs_power_good_mon`

## Requirements
- R1: While reset is active and right after it is released, `pg_pull_low` is 1 (the pin is pulled low, not good).
- R2: With `ss_done`=1 and `fault_latched`=0, a cycle with `rail_above_hi`=1 and `rail_below_lo`=0 starts the rise delay. `pg_pull_low` goes to 0 in the cycle after the edge that samples the RISE_TICKS-th `tick` counted after that start cycle. Ticks in the start cycle are not counted.
- R3: During the rise delay and while good, a rail between the thresholds (both flags 0) neither restarts the rise delay nor releases the indication.
- R4: `rail_below_lo`=1 during the rise delay abandons it. A fresh crossing of the upper threshold is then needed, followed by a full RISE_TICKS ticks.
- R5: While good, `rail_below_lo`=1 starts the release delay. `pg_pull_low` goes to 1 in the cycle after the edge that samples the FALL_TICKS-th `tick` seen with `rail_below_lo` still 1. Ticks in the start cycle are not counted.
- R6: If `rail_below_lo` returns to 0 before the release delay ends, the indication stays good and the next dip starts a full release delay again.
- R7: `ss_done`=0 or `fault_latched`=1 forces `pg_pull_low` to 1 in the same cycle. Once the condition clears, a full rise delay is needed again.
- R8: When both flags are 1 in the same cycle, `rail_below_lo` takes priority: the rail is treated as low.
- R9: Delays advance only on cycles with `tick`=1. Cycles without a tick never change `pg_pull_low` from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base strobe, one cycle wide |
| rail_above_hi | input | 1 | Rail above the upper (90 %) threshold |
| rail_below_lo | input | 1 | Rail below the lower (80 %) threshold |
| ss_done | input | 1 | Soft-start has finished |
| fault_latched | input | 1 | A protection fault is latched |
| pg_pull_low | output | 1 | 1 = open-drain output driven low (not good) |

## Verification
The hardest situations to reach are the timer boundaries. One is a dip below the lower threshold that lands on the last tick before the rise delay would expire. Another is a recovery in the cycle just before the release delay would expire. A third is a forced-low condition that arrives in the middle of a release countdown. Directed sequences step ticks one at a time up to these boundaries and check the output on each side of them. After that, a long seeded random run holds the rail level for stretches long enough to complete the delays. Ticks, soft-start drops, faults and simultaneous flags are mixed in along the way, and a bench reference model predicts the output in every cycle.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [1:0] {
    PG_LOW   = 2'd0,
    PG_RISE  = 2'd1,
    PG_GOOD  = 2'd2,
    PG_FALL  = 2'd3
  } pg_state_e;
endpackage

// File: rtl/pgs_tick_timer.sv
module pgs_tick_timer #(
  parameter int unsigned LIMIT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign expire = run && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr || expire)   cnt <= '0;
    else if (run && tick)     cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm
  import pgs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      qual,
  input  logic      hi,
  input  logic      lo,
  input  logic      rise_exp,
  input  logic      fall_exp,
  output pg_state_e state
);
  pg_state_e nxt;

  always_comb begin
    nxt = state;
    if (!qual) begin
      nxt = PG_LOW;
    end else begin
      unique case (state)
        PG_LOW:  if (hi && !lo) nxt = PG_RISE;
        PG_RISE: if (lo) nxt = PG_LOW;
                 else if (rise_exp) nxt = PG_GOOD;
        PG_GOOD: if (lo) nxt = PG_FALL;
        PG_FALL: if (!lo) nxt = PG_GOOD;
                 else if (fall_exp) nxt = PG_LOW;
        default: nxt = PG_LOW;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PG_LOW;
    else        state <= nxt;
  end
endmodule

// File: rtl/pgs_power_good_mon.sv
module pgs_power_good_mon
  import pgs_pkg::*;
#(
  parameter int unsigned RISE_TICKS = 3000,
  parameter int unsigned FALL_TICKS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rail_above_hi,
  input  logic rail_below_lo,
  input  logic ss_done,
  input  logic fault_latched,
  output logic pg_pull_low
);
  pg_state_e state;
  logic qual, rise_exp, fall_exp;
  logic in_rise, in_fall;

  assign qual    = ss_done && !fault_latched;
  assign in_rise = (state == PG_RISE);
  assign in_fall = (state == PG_FALL);

  pgs_tick_timer #(.LIMIT(RISE_TICKS)) u_rise (
    .clk(clk), .rst_n(rst_n), .clr(!in_rise),
    .run(in_rise && qual && !rail_below_lo),
    .tick(tick), .expire(rise_exp)
  );

  pgs_tick_timer #(.LIMIT(FALL_TICKS)) u_fall (
    .clk(clk), .rst_n(rst_n), .clr(!in_fall),
    .run(in_fall && qual && rail_below_lo),
    .tick(tick), .expire(fall_exp)
  );

  pgs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .qual(qual),
    .hi(rail_above_hi), .lo(rail_below_lo),
    .rise_exp(rise_exp), .fall_exp(fall_exp),
    .state(state)
  );

  assign pg_pull_low = !(qual && (state == PG_GOOD || state == PG_FALL));
endmodule

// File: rtl/pgs_checker.sv
module pgs_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic rail_below_lo,
  input logic ss_done,
  input logic fault_latched,
  input logic pg_pull_low
);
  // R7: forced low while not qualified
  p_forced_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_done || fault_latched) |-> pg_pull_low);

  // R2: release of the pull-down needs a counted tick with the rail not low
  p_assert_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_pull_low) |-> ($past(tick) && !$past(rail_below_lo)));

  // R5: with qualification steady, the pull-down returns only on a tick while low
  p_release_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pg_pull_low) && ss_done && !fault_latched &&
     $past(ss_done) && !$past(fault_latched))
    |-> ($past(tick) && $past(rail_below_lo)));

  // R6: good and rail not low: stays good unless qualification drops
  p_hold_good_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg_pull_low && !rail_below_lo) |=> (!pg_pull_low || !ss_done || fault_latched));

  // R9: no tick, no assertion
  p_no_tick_no_good_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_pull_low && !tick) |=> pg_pull_low);
endmodule

bind pgs_power_good_mon pgs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rail_below_lo(rail_below_lo),
  .ss_done(ss_done), .fault_latched(fault_latched), .pg_pull_low(pg_pull_low)
);

// File: tb/tb_pgs_power_good_mon.sv
module tb_pgs_power_good_mon;
  localparam int RT = 20;
  localparam int FT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, hi = 1'b0, lo = 1'b0, ss = 1'b1, flt = 1'b0;
  logic pull;

  int total = 0, bad = 0;
  int m_st = 0, m_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pgs_power_good_mon #(.RISE_TICKS(RT), .FALL_TICKS(FT)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rail_above_hi(hi),
    .rail_below_lo(lo), .ss_done(ss), .fault_latched(flt), .pg_pull_low(pull)
  );

  // reference model: 0 low, 1 rising, 2 good, 3 falling
  function automatic bit exp_pull();
    return !(ss && !flt && (m_st == 2 || m_st == 3));
  endfunction

  task automatic model_edge();
    if (!rst_n || !ss || flt) begin m_st = 0; m_cnt = 0; end
    else case (m_st)
      0: if (hi && !lo) begin m_st = 1; m_cnt = 0; end
      1: if (lo) m_st = 0;
         else if (tick) begin
           if (m_cnt == RT - 1) m_st = 2; else m_cnt++;
         end
      2: if (lo) begin m_st = 3; m_cnt = 0; end
      default: if (!lo) m_st = 2;
         else if (tick) begin
           if (m_cnt == FT - 1) m_st = 0; else m_cnt++;
         end
    endcase
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: pg_pull_low=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic h, input logic l, input logic t, input string req);
    hi = h; lo = l; tick = t;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(req, pull, exp_pull());
  endtask

  task automatic rise_full(input string req);
    step(1, 0, 0, req);
    for (int i = 0; i < RT - 1; i++) begin
      step(1, 0, 1, req);
      check(req, pull, 1'b1);
      step(1, 0, 0, "R9");
    end
    step(1, 0, 1, req);
    check(req, pull, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int lvl;
    seed = $urandom(32'd24681);
    @(negedge clk);
    // R1: reset
    for (int i = 0; i < 3; i++) begin
      step(1, 0, 1, "R1");
      check("R1", pull, 1'b1);
    end
    rst_n = 1'b1;
    step(0, 0, 0, "R1");
    check("R1", pull, 1'b1);
    // R9: rail high but no ticks
    for (int i = 0; i < 30; i++) step(1, 0, 0, "R9");
    check("R9", pull, 1'b1);
    step(0, 0, 0, "R2");
    // R2: exact rise delay
    rise_full("R2");
    // R3: between thresholds keeps good
    for (int i = 0; i < 3 * RT; i++) step(0, 0, i % 2, "R3");
    check("R3", pull, 1'b0);
    // R6: dip shorter than release delay
    step(0, 1, 1, "R6");
    for (int i = 0; i < FT - 1; i++) step(0, 1, 1, "R6");
    check("R6", pull, 1'b0);
    step(0, 0, 1, "R6");
    check("R6", pull, 1'b0);
    // R5: full release delay
    step(0, 1, 1, "R5");
    for (int i = 0; i < FT - 1; i++) step(0, 1, 1, "R5");
    check("R5", pull, 1'b0);
    step(0, 1, 1, "R5");
    check("R5", pull, 1'b1);
    // R4: dip during rise restarts
    step(1, 0, 0, "R4");
    for (int i = 0; i < RT - 1; i++) step(1, 0, 1, "R4");
    step(0, 1, 1, "R4");
    step(0, 0, 1, "R4");
    check("R4", pull, 1'b1);
    rise_full("R4");
    // R8: both flags treated as low
    step(1, 1, 1, "R8");
    for (int i = 0; i < FT; i++) step(1, 1, 1, "R8");
    check("R8", pull, 1'b1);
    for (int i = 0; i < 2 * RT; i++) step(1, 1, 1, "R8");
    check("R8", pull, 1'b1);
    // R7: soft-start drop forces low at once, then full rise again
    rise_full("R7");
    ss = 1'b0; #1;
    check("R7", pull, 1'b1);
    step(1, 0, 1, "R7");
    ss = 1'b1;
    rise_full("R7");
    flt = 1'b1; #1;
    check("R7", pull, 1'b1);
    step(1, 0, 1, "R7");
    flt = 1'b0; #1;
    check("R7", pull, 1'b1);
    step(0, 1, 0, "R7");
    // random phase
    lvl = 0;
    for (int i = 0; i < 20000; i++) begin
      if ($urandom % 90 == 0) lvl = int'($urandom % 4);
      ss  = ($urandom % 400) != 0;
      flt = ($urandom % 700) == 0;
      step(lvl == 2 || lvl == 3, lvl == 0 || lvl == 3, ($urandom % 3) == 0,
           (lvl == 3) ? "R8" : (lvl == 1) ? "R3" : "R2");
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule